// File: doc/BRIEF.md
# Sync Header Stream Formatter

This transmit-side block produces the 2-bit sync header that goes in front of each 64-bit block of a 64B/66B lane. Thirty-two consecutive blocks form a multiblock, and their sync headers together carry a 32-bit framing word. That word holds the 12-bit parity of the previous multiblock, broken into groups of three with a guard 1 after each group. It also holds a 7-bit command field, an end-of-extended-multiblock flag, and a closing pilot pattern of four zeros followed by a one. Because of the guard 1s spread through the word, that pilot can only appear at the end of a multiblock, so a receiver can find multiblock boundaries from it.

The downstream block takes headers through a valid/ready handshake. `sh_valid` rises on the first clock edge after reset and then stays high. While `sh_ready` is low, the header and the block index shown on the ports hold their values. One block advances only on a cycle where valid and ready are both high. The parity and command inputs are plain control pins. They are sampled only at a multiblock boundary: on the first edge after reset, and on the edge that accepts block 31. Changes to them inside a multiblock therefore cannot corrupt the word being sent. An internal counter sets the end-of-extended-multiblock flag in the last multiblock of every group of `EMB_LEN` multiblocks.

Top module: `shs_fmt`

## Requirements
- R1: While `rst_n` is low, `sh_valid` is 0 and `sh_blk` is 0. On the first rising edge after release, `sh_valid` becomes 1 and shows block 0 of multiblock 0.
- R2: Every header presented is 2'b01 for a word bit of 1 and 2'b10 for a word bit of 0. The codes 2'b00 and 2'b11 never appear with `sh_valid` high.
- R3: Word bit k is sent with block k. Parity bits 11..9 go on blocks 0..2, bits 8..6 on blocks 4..6, bits 5..3 on blocks 8..10, and bits 2..0 on blocks 12..14, most significant first within each group.
- R4: Blocks 3, 7, 11, 15, 19, 21, 23 and 31 always carry a 1 (2'b01). Blocks 27 to 30 always carry a 0 (2'b10).
- R5: With the default `USE_CMD = 0`, the command blocks 16, 17, 18, 20, 24, 25 and 26 carry 0 whatever `cmd_word` holds.
- R6: Block 22 carries 1 only in multiblock number `EMB_LEN-1` of each group of `EMB_LEN`, counted from 0 at reset. In every other multiblock it carries 0.
- R7: Each handshake advances `sh_blk` by one. After block 31 it wraps to 0.
- R8: The parity carried in a multiblock is the value `crc_prev` had at the edge that accepted block 31 of the previous multiblock, or at the first edge after reset. Changes to `crc_prev` in between have no effect.
- R9: While `sh_valid` is high and `sh_ready` is low, `sh_hdr`, `sh_blk` and `sh_valid` stay unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crc_prev | input | 12 | Parity of the previous multiblock |
| cmd_word | input | 7 | Command field (forced to 0 when USE_CMD = 0) |
| sh_valid | output | 1 | Header available |
| sh_ready | input | 1 | Downstream accepts the header this cycle |
| sh_hdr | output | 2 | Sync header for the current block |
| sh_blk | output | 5 | Index of the current block within the multiblock |

## Verification
Header and index change only on the edge of a handshake, and the new values can be observed one edge later. The bench therefore reads the ports on the falling edge that follows, and sets `sh_ready` after that read. Parity sampled on the edge that accepts block 31 first shows on block 0 of the next multiblock, at the very next falling edge. The bench changes `crc_prev` to its next value in the same half-cycle in which it releases block 31. It also drives a wrong value at block 10, which must not reach the header. For the reset check the bench reads at the falling edge before the release, and reads the first header at the falling edge after the release.

// File: rtl/shs_pkg.sv
package shs_pkg;
  localparam int SHS_BLOCKS = 32;
  localparam int SHS_IDX_W  = $clog2(SHS_BLOCKS);
  localparam int SHS_CRC_W  = 12;
  localparam int SHS_CMD_W  = 7;
  localparam int SHS_GROUPS = 4;
  localparam int SHS_GRP_W  = SHS_CRC_W / SHS_GROUPS;

  localparam logic [1:0] SH_ONE  = 2'b01;
  localparam logic [1:0] SH_ZERO = 2'b10;

  typedef struct packed {
    logic [SHS_CRC_W-1:0] crc;
    logic [SHS_CMD_W-1:0] cmd;
    logic                 eoemb;
  } shs_ctrl_t;
endpackage

// File: rtl/shs_idx_ctr.sv
module shs_idx_ctr
  import shs_pkg::*;
#(
  parameter int EMB_LEN = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ready,
  output logic                 valid,
  output logic [SHS_IDX_W-1:0] blk,
  output logic                 load,
  output logic                 eoemb_next
);
  localparam int EMB_W = (EMB_LEN > 1) ? $clog2(EMB_LEN) : 1;
  localparam logic [EMB_W-1:0] EMB_LAST = EMB_W'(EMB_LEN - 1);
  localparam logic [SHS_IDX_W-1:0] BLK_LAST = SHS_IDX_W'(SHS_BLOCKS - 1);

  logic                 valid_q;
  logic [SHS_IDX_W-1:0] blk_q;
  logic [EMB_W-1:0]     mb_q;

  always_comb begin
    load       = !valid_q || (ready && (blk_q == BLK_LAST));
    eoemb_next = (mb_q == EMB_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      blk_q   <= '0;
      mb_q    <= '0;
    end else begin
      if (load) begin
        valid_q <= 1'b1;
        mb_q    <= eoemb_next ? '0 : mb_q + 1'b1;
      end
      if (valid_q && ready) begin
        blk_q <= (blk_q == BLK_LAST) ? '0 : blk_q + 1'b1;
      end
    end
  end

  assign valid = valid_q;
  assign blk   = blk_q;
endmodule

// File: rtl/shs_word_asm.sv
module shs_word_asm
  import shs_pkg::*;
#(
  parameter bit USE_CMD = 1'b0
) (
  input  shs_ctrl_t               ctrl,
  output logic [SHS_BLOCKS-1:0]   word
);
  logic [SHS_CMD_W-1:0] cmd_eff;

  generate
    if (USE_CMD) begin : g_cmd_pass
      assign cmd_eff = ctrl.cmd;
    end else begin : g_cmd_zero
      assign cmd_eff = ctrl.cmd & {SHS_CMD_W{1'b0}};
    end
  endgenerate

  // parity groups: three data bits then a guard one, MSB first
  generate
    for (genvar g = 0; g < SHS_GROUPS; g++) begin : g_grp
      for (genvar j = 0; j < SHS_GRP_W; j++) begin : g_bit
        assign word[g*(SHS_GRP_W+1) + j] = ctrl.crc[SHS_CRC_W-1 - g*SHS_GRP_W - j];
      end
      assign word[g*(SHS_GRP_W+1) + SHS_GRP_W] = 1'b1;
    end
  endgenerate

  // command / flag / pilot half of the word
  assign word[16] = cmd_eff[6];
  assign word[17] = cmd_eff[5];
  assign word[18] = cmd_eff[4];
  assign word[19] = 1'b1;
  assign word[20] = cmd_eff[3];
  assign word[21] = 1'b1;
  assign word[22] = ctrl.eoemb;
  assign word[23] = 1'b1;
  assign word[24] = cmd_eff[2];
  assign word[25] = cmd_eff[1];
  assign word[26] = cmd_eff[0];
  assign word[27] = 1'b0;
  assign word[28] = 1'b0;
  assign word[29] = 1'b0;
  assign word[30] = 1'b0;
  assign word[31] = 1'b1;
endmodule

// File: rtl/shs_hdr_enc.sv
module shs_hdr_enc
  import shs_pkg::*;
(
  input  logic [SHS_BLOCKS-1:0] word,
  input  logic [SHS_IDX_W-1:0]  idx,
  output logic [1:0]            hdr
);
  logic bit_sel;

  always_comb begin
    bit_sel = word[idx];
    hdr     = bit_sel ? SH_ONE : SH_ZERO;
  end
endmodule

// File: rtl/shs_fmt.sv
module shs_fmt
  import shs_pkg::*;
#(
  parameter int EMB_LEN = 4,
  parameter bit USE_CMD = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SHS_CRC_W-1:0] crc_prev,
  input  logic [SHS_CMD_W-1:0] cmd_word,
  output logic                 sh_valid,
  input  logic                 sh_ready,
  output logic [1:0]           sh_hdr,
  output logic [SHS_IDX_W-1:0] sh_blk
);
  logic                  load;
  logic                  eoemb_next;
  shs_ctrl_t             ctrl_in;
  logic [SHS_BLOCKS-1:0] word_next;
  logic [SHS_BLOCKS-1:0] word_q;

  shs_idx_ctr #(.EMB_LEN(EMB_LEN)) u_ctr (
    .clk        (clk),
    .rst_n      (rst_n),
    .ready      (sh_ready),
    .valid      (sh_valid),
    .blk        (sh_blk),
    .load       (load),
    .eoemb_next (eoemb_next)
  );

  always_comb begin
    ctrl_in.crc   = crc_prev;
    ctrl_in.cmd   = cmd_word;
    ctrl_in.eoemb = eoemb_next;
  end

  shs_word_asm #(.USE_CMD(USE_CMD)) u_asm (
    .ctrl (ctrl_in),
    .word (word_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
    end else if (load) begin
      word_q <= word_next;
    end
  end

  shs_hdr_enc u_enc (
    .word (word_q),
    .idx  (sh_blk),
    .hdr  (sh_hdr)
  );
endmodule

// File: rtl/shs_fmt_chk.sv
module shs_fmt_chk
  import shs_pkg::*;
#(
  parameter int EMB_LEN = 4,
  parameter bit USE_CMD = 1'b0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 sh_valid,
  input logic                 sh_ready,
  input logic [1:0]           sh_hdr,
  input logic [SHS_IDX_W-1:0] sh_blk
);
  localparam int CW = (EMB_LEN > 1) ? $clog2(EMB_LEN) : 1;
  logic [CW-1:0] mb_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mb_seen <= '0;
    else if (sh_valid && sh_ready && sh_blk == 5'd31)
      mb_seen <= (mb_seen == CW'(EMB_LEN - 1)) ? '0 : mb_seen + 1'b1;
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |-> (!sh_valid && sh_blk == '0));

  p_legal_hdr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sh_valid |-> (sh_hdr == SH_ONE || sh_hdr == SH_ZERO));

  p_guard_one_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_valid && (sh_blk == 5'd3 || sh_blk == 5'd7 || sh_blk == 5'd11 || sh_blk == 5'd15 ||
                  sh_blk == 5'd19 || sh_blk == 5'd21 || sh_blk == 5'd23 || sh_blk == 5'd31))
    |-> sh_hdr == SH_ONE);

  p_pilot_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_valid && sh_blk >= 5'd27 && sh_blk <= 5'd30) |-> sh_hdr == SH_ZERO);

  generate
    if (!USE_CMD) begin : g_cmd_chk
      p_cmd_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sh_valid && (sh_blk == 5'd16 || sh_blk == 5'd17 || sh_blk == 5'd18 || sh_blk == 5'd20 ||
                      sh_blk == 5'd24 || sh_blk == 5'd25 || sh_blk == 5'd26))
        |-> sh_hdr == SH_ZERO);
    end
  endgenerate

  p_eoemb_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_valid && sh_blk == 5'd22)
    |-> sh_hdr == ((mb_seen == CW'(EMB_LEN - 1)) ? SH_ONE : SH_ZERO));

  p_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_valid && sh_ready && sh_blk != 5'd31) |=> sh_blk == $past(sh_blk) + 5'd1);

  p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_valid && sh_ready && sh_blk == 5'd31) |=> sh_blk == 5'd0);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_valid && !sh_ready) |=> (sh_valid && $stable(sh_hdr) && $stable(sh_blk)));
endmodule

bind shs_fmt shs_fmt_chk #(.EMB_LEN(EMB_LEN), .USE_CMD(USE_CMD)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sh_valid (sh_valid),
  .sh_ready (sh_ready),
  .sh_hdr   (sh_hdr),
  .sh_blk   (sh_blk)
);

// File: tb/shs_fmt_test.sv
module shs_fmt_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] crc_prev = 12'h000;
  logic [6:0]  cmd_word = 7'h7F;
  logic        sh_ready = 1'b0;
  logic        sh_valid;
  logic [1:0]  sh_hdr;
  logic [4:0]  sh_blk;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // each entry: {crc for this multiblock, block index where ready is held low}
  localparam logic [16:0] VEC [6] = '{
    {12'hA5C, 5'd3}, {12'hFFF, 5'd31}, {12'h000, 5'd0},
    {12'h987, 5'd17}, {12'h123, 5'd22}, {12'hE01, 5'd30}
  };

  shs_fmt uut (
    .clk(clk), .rst_n(rst_n), .crc_prev(crc_prev), .cmd_word(cmd_word),
    .sh_valid(sh_valid), .sh_ready(sh_ready), .sh_hdr(sh_hdr), .sh_blk(sh_blk)
  );

  always #4 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] exp_word(logic [11:0] c, logic e);
    logic [31:0] w = '0;
    for (int i = 0; i < 12; i++) w[i + i/3] = c[11-i];
    w[3] = 1; w[7] = 1; w[11] = 1; w[15] = 1; w[19] = 1; w[21] = 1; w[23] = 1; w[31] = 1;
    w[22] = e;
    return w;
  endfunction

  function automatic string req_of(int b);
    if (b == 22) return "R6";
    if (b < 15 && (b % 4) != 3) return "R3";
    if (b == 16 || b == 17 || b == 18 || b == 20 || (b >= 24 && b <= 26)) return "R5";
    return "R4";
  endfunction

  task automatic run_mb(logic [11:0] c, logic e, int stall, logic [11:0] nxt);
    logic [31:0] w = exp_word(c, e);
    sh_ready = 1'b1;
    for (int b = 0; b < 32; b++) begin
      chk("R7 blk", 32'(sh_blk), 32'(b));
      chk("R2 legal", 32'(sh_hdr == 2'b01 || sh_hdr == 2'b10), 32'd1);
      chk(req_of(b), 32'(sh_hdr), w[b] ? 32'h1 : 32'h2);
      if (b == stall) begin
        sh_ready = 1'b0;
        for (int s = 0; s < 2; s++) begin
          @(negedge clk);
          chk("R9 hold blk", 32'(sh_blk), 32'(b));
          chk("R9 hold hdr", 32'(sh_hdr), w[b] ? 32'h1 : 32'h2);
          chk("R9 hold valid", 32'(sh_valid), 32'd1);
        end
        sh_ready = 1'b1;
      end
      if (b == 5)  cmd_word = 7'h2A;       // R5: command input ignored
      if (b == 10) crc_prev = ~c;          // R8: mid-multiblock change ignored
      if (b == 31) crc_prev = nxt;         // R8: sampled at block 31 acceptance
      @(negedge clk);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(8 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    crc_prev = VEC[0][16:5];
    repeat (3) @(negedge clk);
    chk("R1 valid in reset", 32'(sh_valid), 32'd0);
    chk("R1 blk in reset", 32'(sh_blk), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid after release", 32'(sh_valid), 32'd1);
    for (int v = 0; v < 6; v++) begin
      run_mb(VEC[v][16:5], (v % 4) == 3, int'(VEC[v][4:0]),
             (v < 5) ? VEC[v+1][16:5] : 12'h3C3);
    end
    // multiblock 6: a long stall on block 31 while crc changes late
    sh_ready = 1'b1;
    repeat (31) @(negedge clk);
    sh_ready = 1'b0;
    crc_prev = 12'h111;
    repeat (3) @(negedge clk);
    chk("R9 stall at 31", 32'(sh_blk), 32'd31);
    crc_prev = 12'h6B2;
    sh_ready = 1'b1;
    @(negedge clk);
    run_mb(12'h6B2, 1'b1, 40, 12'h555);   // multiblock 7 ends the second group (R6, R8)
    // mid-stream reset
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    sh_ready = 1'b0;
    @(negedge clk);
    chk("R1 valid after mid reset", 32'(sh_valid), 32'd0);
    chk("R1 blk after mid reset", 32'(sh_blk), 32'd0);
    crc_prev = 12'h0F0;
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 valid restart", 32'(sh_valid), 32'd1);
    run_mb(12'h0F0, 1'b0, 40, 12'hAAA);
    run_mb(12'hAAA, 1'b0, 40, 12'h000);
    done = 1'b1;
    summary();
    $finish;
  end
endmodule